// File: doc/BRIEF.md
# Single-Error-Correcting Sector Code Decoder

The block checks one sector of stored data against its 24-bit single-error-correcting code. At the end of a sector read it receives the raw 32-bit parity word that was accumulated during the read, and the 24-bit code that was written to the spare area with the sector. It folds the raw word into the 24-bit stored form, inverts it, and XORs it with the code read back. The result is a syndrome, which the block sorts into four classes: clean, a correctable flip in the data, a flip inside the code field, or uncorrectable.

For a correctable data error it reports the byte offset within the sector and a one-hot mask for the bad bit. It can also repair the byte itself through a byte-wide port to the sector RAM, with a read followed by a write. A request is accepted only while the block is idle, and a one-cycle done pulse marks the end of each request.

Top module: `ecc_sec_decoder`

## Requirements
- R1: The computed code is the bitwise inverse of {raw[27:16], raw[11:0]}. The syndrome is that code XOR stored_code_i.
- R2: A zero syndrome gives status 0 (clean). It also gives byte offset 0, mask 0 and no RAM access.
- R3: If syndrome[23:12] XOR syndrome[11:0] equals 12'hFFF and syndrome[23:15] is below SECTOR_BYTES, the status is 1 (data corrected). The byte offset is syndrome[23:15] and the mask is 1 << syndrome[14:12].
- R4: If the R3 pattern holds but syndrome[23:15] is SECTOR_BYTES or more, the status is 3 (uncorrectable). There is no RAM access, and the offset and mask are 0.
- R5: A syndrome with exactly one bit set gives status 2 (code-field error). Offset and mask are 0, and the sector RAM is not touched.
- R6: Every other non-zero syndrome gives status 3 with offset and mask 0.
- R7: When fix_en_i is high and the status is 1, the block does two RAM accesses. It reads the flagged byte in the first cycle after start. In the next cycle it writes rdata XOR mask to the same address. The RAM returns read data one cycle after the read request. done_o rises one cycle after the write, which is three cycles after the start edge.
- R8: In every other case done_o is high in the cycle right after the start edge. done_o is always a single-cycle pulse, and the results hold until the next accepted start.
- R9: start_i is ignored while busy_o is high. busy_o is high from the accepted start through the done cycle.
- R10: Raw bits 15:12 and 31:28 have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a decode when idle |
| fix_en_i | input | 1 | Enables the repair of the RAM byte |
| raw_par_i | input | 32 | Raw parity word from the read |
| stored_code_i | input | 24 | Code read back from the spare area |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 clean, 1 data corrected, 2 code-field error, 3 uncorrectable |
| byte_off_o | output | 9 | Byte offset of the flipped bit |
| bit_mask_o | output | 8 | One-hot mask of the flipped bit |
| mem_req_o | output | 1 | Sector RAM access request |
| mem_we_o | output | 1 | Write strobe of the RAM access |
| mem_addr_o | output | ADDR_W | RAM byte address |
| mem_wdata_o | output | 8 | Repaired byte |
| mem_rdata_i | input | 8 | RAM read data, one cycle after the request |

## Verification
The bench is built with a sector shorter than the 9-bit offset range. It sweeps every offset and bit index, so a design that skips the bound check would write past the end of the sector where R4 requires uncorrectable with no access. Each of the 24 single-bit code-field syndromes is also run with repair enabled; a design that mixes these up with data errors would corrupt a RAM byte. Clean cases use random raw words with junk in the unused nibbles, which catches a missing inversion or a wrong fold. Start pulses sent during a repair check that the latched results and the single done pulse are not disturbed.

// File: rtl/ecc_sec_pkg.sv
package ecc_sec_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_IDX_W = 3;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_DATA_FIX = 2'd1,
    ST_CODE_ERR = 2'd2,
    ST_UNCORR   = 2'd3
  } ecc_status_e;
endpackage

// File: rtl/ecc_code_pack.sv
module ecc_code_pack #(
  parameter int HALF_W = 12,
  parameter int HI_LSB = 16,
  localparam int RAW_W  = 2 * HI_LSB,
  localparam int CODE_W = 2 * HALF_W
) (
  input  logic [RAW_W-1:0]  raw_i,
  output logic [CODE_W-1:0] code_o
);
  // fold the two parity halves together, then invert
  assign code_o = ~{raw_i[HI_LSB+HALF_W-1:HI_LSB], raw_i[HALF_W-1:0]};
endmodule

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
  import ecc_sec_pkg::*;
#(
  parameter int HALF_W       = 12,
  parameter int SECTOR_BYTES = 512,
  localparam int CODE_W = 2 * HALF_W,
  localparam int OFF_W  = CODE_W - HALF_W - BIT_IDX_W
) (
  input  logic [CODE_W-1:0] syn_i,
  output ecc_status_e       status_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [BYTE_W-1:0] mask_o
);
  logic [HALF_W-1:0]    lo, hi;
  logic [OFF_W-1:0]     off;
  logic [BIT_IDX_W-1:0] bidx;
  logic                 complementary, single_bit, in_range;

  assign lo            = syn_i[HALF_W-1:0];
  assign hi            = syn_i[CODE_W-1:HALF_W];
  assign off           = syn_i[CODE_W-1:HALF_W+BIT_IDX_W];
  assign bidx          = syn_i[HALF_W+BIT_IDX_W-1:HALF_W];
  assign complementary = &(lo ^ hi);
  assign single_bit    = (syn_i & (syn_i - 1'b1)) == '0;
  assign in_range      = 32'(off) < SECTOR_BYTES;

  always_comb begin
    status_o = ST_UNCORR;
    off_o    = '0;
    mask_o   = '0;
    if (syn_i == '0) begin
      status_o = ST_CLEAN;
    end else if (complementary) begin
      if (in_range) begin
        status_o = ST_DATA_FIX;
        off_o    = off;
        mask_o   = BYTE_W'(1) << bidx;
      end
    end else if (single_bit) begin
      status_o = ST_CODE_ERR;
    end
  end
endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fix_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o,
  output logic rd_o,
  output logic wr_o
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_DONE} state_e;
  state_e state_q, state_d;

  assign accept_o = start_i && (state_q == S_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = fix_i ? S_RD : S_DONE;
      S_RD:   state_d = S_WR;
      S_WR:   state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = state_q != S_IDLE;
  assign done_o = state_q == S_DONE;
  assign rd_o   = state_q == S_RD;
  assign wr_o   = state_q == S_WR;
endmodule

// File: rtl/ecc_sec_decoder.sv
module ecc_sec_decoder
  import ecc_sec_pkg::*;
#(
  parameter int HALF_W       = 12,
  parameter int HI_LSB       = 16,
  parameter int SECTOR_BYTES = 512,
  localparam int RAW_W  = 2 * HI_LSB,
  localparam int CODE_W = 2 * HALF_W,
  localparam int OFF_W  = CODE_W - HALF_W - BIT_IDX_W,
  localparam int ADDR_W = $clog2(SECTOR_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fix_en_i,
  input  logic [RAW_W-1:0]  raw_par_i,
  input  logic [CODE_W-1:0] stored_code_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [OFF_W-1:0]  byte_off_o,
  output logic [BYTE_W-1:0] bit_mask_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  logic [CODE_W-1:0] calc_code, syn;
  ecc_status_e       cls_status, status_q;
  logic [OFF_W-1:0]  cls_off, off_q;
  logic [BYTE_W-1:0] cls_mask, mask_q;
  logic              accept, rd, wr;

  ecc_code_pack #(.HALF_W(HALF_W), .HI_LSB(HI_LSB)) u_pack (
    .raw_i (raw_par_i),
    .code_o(calc_code)
  );

  assign syn = calc_code ^ stored_code_i;

  ecc_syn_classify #(.HALF_W(HALF_W), .SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .syn_i   (syn),
    .status_o(cls_status),
    .off_o   (cls_off),
    .mask_o  (cls_mask)
  );

  ecc_rmw_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .fix_i   (fix_en_i && (cls_status == ST_DATA_FIX)),
    .accept_o(accept),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .rd_o    (rd),
    .wr_o    (wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= ST_CLEAN;
      off_q    <= '0;
      mask_q   <= '0;
    end else if (accept) begin
      status_q <= cls_status;
      off_q    <= cls_off;
      mask_q   <= cls_mask;
    end
  end

  assign status_o    = status_q;
  assign byte_off_o  = off_q;
  assign bit_mask_o  = mask_q;
  assign mem_req_o   = rd || wr;
  assign mem_we_o    = wr;
  assign mem_addr_o  = off_q[ADDR_W-1:0];
  assign mem_wdata_o = mem_rdata_i ^ mask_q;
endmodule

module ecc_sec_decoder_chk #(
  parameter int SECTOR_BYTES = 512,
  parameter int OFF_W        = 9,
  parameter int ADDR_W       = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        status_o,
  input logic [OFF_W-1:0]  byte_off_o,
  input logic [7:0]        bit_mask_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_write_follows_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o));

  p_write_same_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_addr_o == $past(mem_addr_o));

  p_access_only_data_fix_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (status_o == 2'd1));

  p_mask_onehot_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd1) |-> ($countones(bit_mask_o) == 1 && 32'(byte_off_o) < SECTOR_BYTES));

  p_fields_zero_otherwise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 2'd1) |-> (bit_mask_o == 8'd0 && byte_off_o == '0));

  p_results_hold_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(status_o) && $stable(byte_off_o) && $stable(bit_mask_o)));
endmodule

bind ecc_sec_decoder ecc_sec_decoder_chk #(
  .SECTOR_BYTES(SECTOR_BYTES), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .status_o(status_o), .byte_off_o(byte_off_o), .bit_mask_o(bit_mask_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
);

// File: tb/ecc_sec_decoder_tb.sv
module ecc_sec_decoder_tb;
  localparam int SB = 384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, fix_en_i = 1'b0;
  logic [31:0] raw_par_i = '0;
  logic [23:0] stored_code_i = '0;
  logic        busy_o, done_o, mem_req_o, mem_we_o;
  logic [1:0]  status_o;
  logic [8:0]  byte_off_o, mem_addr_o;
  logic [7:0]  bit_mask_o, mem_wdata_o;
  logic [7:0]  mem_rdata = '0;

  logic [7:0]  ram [512];
  logic [7:0]  exp_ram [512];
  int          acc_cnt = 0;
  int          checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  ecc_sec_decoder #(.SECTOR_BYTES(SB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .fix_en_i(fix_en_i),
    .raw_par_i(raw_par_i), .stored_code_i(stored_code_i),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
    .byte_off_o(byte_off_o), .bit_mask_o(bit_mask_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) ram[i] <= 8'(i * 7 + 3);
    end else if (mem_req_o) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we_o) ram[mem_addr_o] <= mem_wdata_o;
      else          mem_rdata <= ram[mem_addr_o];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_status(input logic [23:0] s);
    if (s == 0) return 2'd0;
    if ((s[23:12] ^ s[11:0]) == 12'hFFF) return (int'(s[23:15]) < SB) ? 2'd1 : 2'd3;
    if ($countones(s) == 1) return 2'd2;
    return 2'd3;
  endfunction

  task automatic run_case(input logic [31:0] raw, input logic [23:0] syn,
                          input logic fix, input logic poke, input string req);
    logic [23:0] code;
    logic [1:0]  est;
    logic [8:0]  eoff;
    logic [7:0]  emask;
    logic        efix;
    int          lat, acc0, bad;
    code  = ~{raw[27:16], raw[11:0]};
    est   = exp_status(syn);
    eoff  = (est == 2'd1) ? syn[23:15] : 9'd0;
    emask = (est == 2'd1) ? 8'(1 << syn[14:12]) : 8'd0;
    efix  = fix && (est == 2'd1);
    @(negedge clk);
    acc0 = acc_cnt;
    raw_par_i = raw; stored_code_i = code ^ syn; fix_en_i = fix; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; lat = 1;
    if (poke && !done_o) begin
      start_i = 1'b1; raw_par_i = ~raw; stored_code_i = ~stored_code_i;
    end
    while (!done_o && lat < 8) begin
      @(negedge clk);
      start_i = 1'b0; lat++;
    end
    start_i = 1'b0;
    chk(status_o == est, req, "status", status_o, est);
    chk(byte_off_o == eoff, req, "offset", byte_off_o, eoff);
    chk(bit_mask_o == emask, req, "mask", bit_mask_o, emask);
    chk(lat == (efix ? 3 : 1), efix ? "R7" : "R8", "done latency", lat, efix ? 3 : 1);
    chk((acc_cnt - acc0) == (efix ? 2 : 0), efix ? "R7" : req, "ram accesses",
        acc_cnt - acc0, efix ? 2 : 0);
    if (efix) exp_ram[eoff] = exp_ram[eoff] ^ emask;
    bad = 0;
    for (int i = 0; i < 512; i++) if (ram[i] !== exp_ram[i]) bad++;
    chk(bad == 0, efix ? "R7" : req, "ram mismatching bytes", bad, 0);
    @(negedge clk);
    chk(!done_o, "R8", "done pulse width", done_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) exp_ram[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && !busy_o && !mem_req_o, "R8", "reset outputs",
        {done_o, busy_o, mem_req_o}, 0);
    chk(status_o == 2'd0 && bit_mask_o == 0, "R2", "reset status", status_o, 0);

    // R1 R2 R10: clean reads with junk in unused raw nibbles
    for (int k = 0; k < 24; k++) run_case($urandom, 24'd0, k[0], 1'b0, "R1");

    // R3 R4: every offset and bit index, sector shorter than offset range
    for (int o = 0; o < 512; o++) begin
      for (int b = 0; b < 8; b++) begin
        logic [11:0] h;
        h = {9'(o), 3'(b)};
        run_case($urandom, {h, ~h}, (o % 3) != 0, (o % 37 == 0) && b == 1,
                 (o < SB) ? "R3" : "R4");
      end
    end

    // R5: single-bit code-field errors with repair enabled
    for (int i = 0; i < 24; i++) run_case($urandom, 24'(1) << i, 1'b1, 1'b0, "R5");

    // R6: multi-bit patterns
    run_case(32'hF000_F000, 24'h000003, 1'b1, 1'b0, "R6");
    run_case(32'h0, 24'hFFFFFF, 1'b1, 1'b0, "R6");
    for (int k = 0; k < 300; k++) run_case($urandom, 24'($urandom), 1'b1, 1'b0, "R6");

    // R9 R10: repeat repairs with start pokes and varied unused raw bits
    for (int k = 0; k < 8; k++) begin
      logic [11:0] h;
      h = {9'(k * 40), 3'(k)};
      run_case({4'(k), 12'h5A5, 4'(~k), 12'h3C3}, {h, ~h}, 1'b1, 1'b1, "R9");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule